// File: doc/BRIEF.md
# Amplifier Offset Trim Sequencer

The sequencer calibrates the input offset of an amplifier whose input stage holds an N-type and a P-type differential pair. A single start pulse runs a hardware successive-approximation search on a 7-bit signed-magnitude trim code for each pair, N first and then P. Every trial code is followed by a settling wait and an ADC conversion. The block drives the trim codes and reference enables straight onto the amplifier. It leaves the finished codes in place and signals completion with a one-cycle pulse.

Each trim output is 8 bits wide. Bit 7 turns on the calibration reference of that pair. Bit 6 is the sign: 1 compensates a positive offset and 0 a negative one. Bits 5:0 hold the magnitude, where 0 means no trim and 63 means full trim. The first conversion of a pair uses sign 1 and magnitude 0, and its top three result bits decide what happens next. If they are all ones, the sign stays 1. If they are all zeros, the sign is cleared. Any other value means the offset is already small, so that pair is skipped. The magnitude bits are then tried from bit 5 down to bit 0. A trial bit is dropped when the result MSB differs from the MSB of that first conversion.

Top module: `offset_trim_seq`

## Requirements
- R1: While reset is active, and right after it, both trim outputs read 0x40, and trim_mode, done and adc_start are 0.
- R2: A start pulse taken while idle raises trim_mode and loads the N trim output with 0xC0 on the next cycle, with bit 7 of the P output at 0.
- R3: adc_start is a single-cycle pulse. It rises no sooner than SETTLE_CYCLES cycles after the last change of either trim output.
- R4: On the first conversion of a pair, top three result bits of 111 keep the sign at 1 and 000 clear it. Any other value ends that pair with the code 0x40.
- R5: The search tries magnitude bits 5, 4, 3, 2, 1, 0 in that order. A trial bit is cleared when the result MSB differs from the MSB of the pair's first conversion. A searched pair ends with the sign of its offset and a magnitude within 1 of min(|offset|, 63).
- R6: At most one of the two reference-enable bits (bit 7) is set at any time, and only while trim_mode is 1. It is the bit of the pair being calibrated when adc_start rises.
- R7: When the P pair is finished, done pulses for one cycle. In that cycle trim_mode and both bit-7 enables are 0, and the sign and magnitude bits keep their calibrated values.
- R8: A start pulse during a calibration is ignored: the run continues and the N output does not reload 0xC0.
- R9: A start pulse in the same cycle as done begins a new calibration: on the next cycle trim_mode is 1 and the N output reads 0xC0.
- R10: adc_result is read only in a cycle where adc_ready is 1. Values present at other times have no effect on the codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Calibration request pulse |
| done | output | 1 | One-cycle completion pulse |
| adc_start | output | 1 | Conversion request pulse |
| adc_ready | input | 1 | Conversion result valid |
| adc_result | input | ADC_W | Conversion result |
| trim_mode | output | 1 | Puts the amplifier in its trim configuration |
| trim_n | output | 8 | N-pair trim: enable, sign, magnitude |
| trim_p | output | 8 | P-pair trim: enable, sign, magnitude |

## Verification
The completion pulse and the acceptance of a fresh start request can land in the same cycle. This is the one place where the end of a run and the start of the next one touch. The bench provokes it by driving start in the very cycle where done is observed high. It then checks that the codes captured in that cycle carry the finished calibration and that the following cycle already shows trim mode with the N register reloaded. In separate runs, start is also pulsed in the middle of the P-pair search to confirm that an overlapping request leaves the run undisturbed.

// File: rtl/offset_trim_seq.sv
module offset_trim_seq #(
  parameter int ADC_W         = 10,
  parameter int SETTLE_CYCLES = 105000  // 1.05 ms at 100 MHz
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             adc_start,
  input  logic             adc_ready,
  input  logic [ADC_W-1:0] adc_result,
  output logic             trim_mode,
  output logic [7:0]       trim_n,
  output logic [7:0]       trim_p
);
  localparam int MAG_W = 6;
  localparam int BIT_W = $clog2(MAG_W);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [7:0] RST_CODE = 8'h40;
  localparam logic [7:0] CAL_CODE = 8'hC0;
  localparam logic [CNT_W-1:0] T_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CONV} state_t;

  state_t           state;
  logic             pair, srch, pol;
  logic [BIT_W-1:0] bidx;
  logic [CNT_W-1:0] timer;
  logic [7:0]       cur, upd;
  logic             pair_end;

  wire [2:0] top3      = adc_result[ADC_W-1 -: 3];
  wire       top_ones  = &top3;
  wire       top_zeros = ~|top3;

  assign cur = pair ? trim_p : trim_n;

  always_comb begin
    upd      = cur;
    pair_end = 1'b0;
    if (!srch) begin
      if (top_ones) begin
        upd[MAG_W]   = 1'b1;
        upd[MAG_W-1] = 1'b1;
      end else if (top_zeros) begin
        upd[MAG_W]   = 1'b0;
        upd[MAG_W-1] = 1'b1;
      end else begin
        pair_end = 1'b1;
      end
    end else begin
      if (adc_result[ADC_W-1] != pol) upd[bidx] = 1'b0;
      if (bidx == '0) pair_end = 1'b1;
      else            upd[bidx - 1'b1] = 1'b1;
    end
    if (pair_end) upd[7] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pair      <= 1'b0;
      srch      <= 1'b0;
      pol       <= 1'b0;
      bidx      <= '0;
      timer     <= '0;
      trim_n    <= RST_CODE;
      trim_p    <= RST_CODE;
      trim_mode <= 1'b0;
      adc_start <= 1'b0;
      done      <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          trim_mode <= 1'b1;
          trim_n    <= CAL_CODE;
          pair      <= 1'b0;
          srch      <= 1'b0;
          timer     <= T_LOAD;
          state     <= S_SETTLE;
        end
        S_SETTLE: begin
          if (timer == '0) begin
            adc_start <= 1'b1;
            state     <= S_CONV;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_CONV: if (adc_ready) begin
          if (pair) trim_p <= upd;
          else      trim_n <= upd;
          if (!pair_end) begin
            srch  <= 1'b1;
            timer <= T_LOAD;
            state <= S_SETTLE;
            if (!srch) begin
              pol  <= top_ones;
              bidx <= BIT_W'(MAG_W - 1);
            end else begin
              bidx <= bidx - 1'b1;
            end
          end else if (!pair) begin
            pair   <= 1'b1;
            srch   <= 1'b0;
            trim_p <= CAL_CODE;
            timer  <= T_LOAD;
            state  <= S_SETTLE;
          end else begin
            trim_mode <= 1'b0;
            done      <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/offset_trim_chk.sv
module offset_trim_chk #(
  parameter int SETTLE_CYCLES = 105000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       adc_start,
  input logic       trim_mode,
  input logic [7:0] trim_n,
  input logic [7:0] trim_p
);
  localparam int GW = $clog2(SETTLE_CYCLES + 2);
  logic [15:0]   prev;
  logic [GW-1:0] gap;
  wire changed = ({trim_n, trim_p} != prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 16'h4040;
      gap  <= '0;
    end else begin
      prev <= {trim_n, trim_p};
      if (changed) gap <= GW'(1);
      else if (gap < GW'(SETTLE_CYCLES)) gap <= gap + 1'b1;
    end
  end

  assert_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (!changed && gap >= GW'(SETTLE_CYCLES)));
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_one_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({trim_n[7], trim_p[7]}) <= 1);
  assert_ref_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_n[7] || trim_p[7]) |-> trim_mode);
  assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!trim_mode && !trim_n[7] && !trim_p[7]));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_entry_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trim_mode) |-> (trim_n == 8'hC0 && !trim_p[7]));
endmodule

bind offset_trim_seq offset_trim_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .adc_start(adc_start),
  .trim_mode(trim_mode), .trim_n(trim_n), .trim_p(trim_p)
);

// File: tb/sim_offset_trim_seq.sv
`timescale 1ns/1ps
module sim_offset_trim_seq;
  localparam int ADC_W  = 10;
  localparam int SETTLE = 20;

  logic             clk = 0, rst_n = 0, start = 0, adc_ready = 0;
  logic [ADC_W-1:0] adc_result = '0;
  logic             done, adc_start, trim_mode;
  logic [7:0]       trim_n, trim_p;

  int vectors = 0, misses = 0, cycles = 0;
  int off_n = 0, off_p = 0;

  offset_trim_seq #(.ADC_W(ADC_W), .SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .adc_start(adc_start), .adc_ready(adc_ready), .adc_result(adc_result),
    .trim_mode(trim_mode), .trim_n(trim_n), .trim_p(trim_p));

  always #5 clk = ~clk;

  function automatic int adc_model(input int off, input logic [7:0] code);
    int tv, r;
    tv = code[6] ? int'(code[5:0]) : -int'(code[5:0]);
    r  = 512 + 64 * (off - tv);
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  function automatic bit code_ok(input int off, input logic [7:0] code);
    int ideal, mag;
    if (code[7]) return 0;
    if (off >= -6 && off <= 5) return code == 8'h40;
    if (code[6] != (off > 0)) return 0;
    ideal = (off < 0) ? -off : off;
    if (ideal > 63) ideal = 63;
    mag = int'(code[5:0]);
    return (mag - ideal <= 1) && (ideal - mag <= 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ADC responder; drives junk on the result bus when not ready (R10)
  bit pend = 0;
  int lat = 0;
  always @(negedge clk) begin
    adc_ready  = 1'b0;
    adc_result = ADC_W'($urandom);
    if (!rst_n) pend = 0;
    else if (pend) begin
      if (lat == 0) begin
        pend = 0;
        adc_ready = 1'b1;
        if (trim_n[7]) adc_result = ADC_W'(adc_model(off_n, trim_n));
        else           adc_result = ADC_W'(adc_model(off_p, trim_p));
      end else lat--;
    end else if (adc_start) begin
      pend = 1;
      lat  = $urandom_range(0, 3);
    end
  end

  // settle gap and reference selection monitor
  logic [15:0] prev_codes = 16'h4040;
  int gap = 0;
  always @(negedge clk) begin
    cycles++;
    if ({trim_n, trim_p} != prev_codes) gap = 0; else gap++;
    prev_codes = {trim_n, trim_p};
    if (rst_n && adc_start) begin
      check(gap >= SETTLE, "R3 settle gap", gap, SETTLE);
      check($countones({trim_n[7], trim_p[7]}) == 1, "R6 one reference", {trim_n[7], trim_p[7]}, 1);
    end
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic run(input int on, input int op, input bit chained, input bit poke, input bit chain_after);
    bit poked = 0;
    bit fin = 0;
    off_n = on;
    off_p = op;
    if (!chained) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      check(trim_mode && trim_n == 8'hC0 && !trim_p[7], "R2 entry", {trim_mode, trim_n}, 9'h1C0);
    end
    for (int i = 0; i < 5000 && !fin; i++) begin
      @(negedge clk);
      start = 0;
      if (done) begin
        fin = 1;
        check(code_ok(on, trim_n), "R5 N code", trim_n, on);
        check(code_ok(op, trim_p), "R5 P code", trim_p, op);
        check(!trim_mode, "R7 mode clear", trim_mode, 0);
        if (chain_after) begin
          start = 1;
          @(negedge clk); start = 0;
          check(trim_mode && trim_n == 8'hC0, "R9 start at done", {trim_mode, trim_n}, 9'h1C0);
        end else begin
          @(negedge clk);
          check(!done, "R7 done pulse", done, 0);
        end
      end else if (poke && !poked && trim_p[7]) begin
        poked = 1;
        start = 1;
        @(negedge clk); start = 0;
        check(!trim_n[7] && trim_p[7], "R8 start ignored", {trim_n[7], trim_p[7]}, 1);
      end
    end
    check(fin, "R7 done seen", fin, 1);
  endtask

  initial begin
    int corners[10];
    void'($urandom(32'd4711));
    corners = '{0, 5, 6, -6, -7, 63, -64, 100, -100, 1};
    repeat (3) @(negedge clk);
    check(trim_n == 8'h40 && trim_p == 8'h40 && !trim_mode && !done && !adc_start,
          "R1 reset", {trim_n, trim_p}, 16'h4040);
    rst_n = 1;
    @(negedge clk);
    check(trim_n == 8'h40 && trim_p == 8'h40 && !trim_mode, "R1 after reset", {trim_n, trim_p}, 16'h4040);

    // R4 corners: skip window and sign edges
    for (int k = 0; k < 10; k++) run(corners[k], corners[9 - k], 0, 0, 0);

    // R8: start during P search
    run(30, -40, 0, 1, 0);
    run(-3, 50, 0, 1, 0);

    // R9: start in done cycle, chained runs
    run(12, -25, 0, 0, 1);
    run(-45, 2, 1, 0, 1);
    run(70, 9, 1, 0, 0);

    // random offsets (R5, R10)
    for (int k = 0; k < 30; k++)
      run($urandom_range(0, 180) - 90, $urandom_range(0, 180) - 90, 0, k % 7 == 3, 0);

    // R1: reset in the middle of a run
    off_n = 40; off_p = 40;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (37) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(trim_n == 8'h40 && trim_p == 8'h40 && !trim_mode && !adc_start, "R1 mid-run reset",
          {trim_n, trim_p}, 16'h4040);
    rst_n = 1;
    run(-33, 33, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule